// File: doc/BRIEF.md
# Dual-Port IDE Host Adapter

This block connects a 16-bit host register bus to two IDE device ports. Host accesses to the two register windows are broadcast to both device ports. The host word offset and byte-lane mask are translated into an IDE register offset, a device-side lane mask and device-side write data. Read data coming back from the ports is merged into one host word.

DMA transfers are carried in the same way. DMA write data, DMA strobes and the DMA acknowledge level go to every populated port. DMA read data from the ports is merged into one word.

Each port has an interrupt line and a DMA-request line. The interrupt lines are combined into one registered host interrupt, and the DMA-request lines into one registered host DMA request. All data paths are combinational. Each port also receives a fixed cable-select strap and an indication of whether the second port is populated.

Top module: `ide_pair_adapter`

## Requirements
- R1: Unless R2 or R3 applies, the IDE register offset `dev_reg_off` is twice `host_word_off`. The device lane mask and the device write data equal the host values.
- R2: When `host_mask` is exactly 0xFF00, `dev_reg_off` is twice the word offset plus one, and `dev_mask` is 0x00FF. `dev_wdata` carries `host_wdata[15:8]` in its low byte, with zeros above. The merged read byte is returned in `host_rdata[15:8]`, with `host_rdata[7:0]` zero.
- R3: When a window-0 strobe is active and `host_mask` is 0xFFFF at word offset 1, the access uses word offset 0, so `dev_reg_off` is 0. Window-1 accesses and other masks are not redirected.
- R4: `host_rdata` is the bitwise AND of the device lane mask and the `dev_rdata` word of each port whose `dev_present` bit is 1. An absent port contributes all ones, so with no port present and a full mask `host_rdata` is 0xFFFF.
- R5: `host_dma_rdata` is 0xFFFF ANDed with the `dev_dma_rdata` word of each present port.
- R6: Each window read and write strobe reaches port p exactly when the host strobe is active and `dev_present[p]` is 1.
- R7: DMA read strobes, DMA write strobes and the DMA acknowledge level reach port p exactly when the host signal is active and `dev_present[p]` is 1. `dev_dma_wdata` equals `host_dma_wdata`.
- R8: `host_irq` equals the OR of both `dev_irq` bits as sampled at the previous rising clock edge.
- R9: `host_dmarq` equals the OR of both `dev_dmarq` bits as sampled at the previous rising clock edge.
- R10: `dev_csel` is 2'b10, so port 0 is strapped to value 0 and port 1 to value 1. Both bits of `dev_dasp` equal `dev_present[1]`.
- R11: After a clock edge with `rst_n` low, `host_irq` and `host_dmarq` are 0 regardless of the device lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs0_rd | input | 1 | Read strobe, register window 0 |
| host_cs0_wr | input | 1 | Write strobe, register window 0 |
| host_cs1_rd | input | 1 | Read strobe, register window 1 |
| host_cs1_wr | input | 1 | Write strobe, register window 1 |
| host_word_off | input | 3 | Host word offset inside the window |
| host_mask | input | 16 | Host byte-lane mask |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Merged read data |
| host_dma_rd | input | 1 | DMA read strobe |
| host_dma_wr | input | 1 | DMA write strobe |
| host_dma_wdata | input | 16 | DMA write data |
| host_dma_rdata | output | 16 | Merged DMA read data |
| host_dmack | input | 1 | DMA acknowledge level |
| host_irq | output | 1 | Registered combined interrupt |
| host_dmarq | output | 1 | Registered combined DMA request |
| dev_present | input | 2 | Port populated, one bit per port |
| dev_cs0_rd | output | 2 | Per-port window-0 read strobe |
| dev_cs0_wr | output | 2 | Per-port window-0 write strobe |
| dev_cs1_rd | output | 2 | Per-port window-1 read strobe |
| dev_cs1_wr | output | 2 | Per-port window-1 write strobe |
| dev_reg_off | output | 4 | IDE register offset |
| dev_mask | output | 16 | Device-side lane mask |
| dev_wdata | output | 16 | Device-side write data |
| dev_rdata | input | 32 | Read data, port p in bits [16p+15:16p] |
| dev_dma_rd | output | 2 | Per-port DMA read strobe |
| dev_dma_wr | output | 2 | Per-port DMA write strobe |
| dev_dma_wdata | output | 16 | DMA write data to the ports |
| dev_dma_rdata | input | 32 | DMA read data, port p in bits [16p+15:16p] |
| dev_dmack | output | 2 | Per-port DMA acknowledge |
| dev_irq | input | 2 | Per-port interrupt |
| dev_dmarq | input | 2 | Per-port DMA request |
| dev_csel | output | 2 | Cable-select strap per port |
| dev_dasp | output | 2 | Second-port-populated indication per port |

## Verification
Window accesses are tried with full, upper-only, lower-only and irregular masks. This separates the odd-offset lane remap from the plain doubling, and from a mask that merely contains the upper byte. Full-mask accesses at offset 1 in both windows show that the redirect is limited to window 0. Every combination of populated ports is used under varied read data, so the all-ones contribution of an empty port and the AND merge of two ports are both observed. Interrupt and DMA-request patterns that toggle every cycle, including during reset, expose a missing or doubled register stage.

// File: rtl/ide_pair_adapter.sv
module ide_pair_adapter #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs0_rd,
  input  logic              host_cs0_wr,
  input  logic              host_cs1_rd,
  input  logic              host_cs1_wr,
  input  logic [AW-1:0]     host_word_off,
  input  logic [DW-1:0]     host_mask,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              host_dma_rd,
  input  logic              host_dma_wr,
  input  logic [DW-1:0]     host_dma_wdata,
  output logic [DW-1:0]     host_dma_rdata,
  input  logic              host_dmack,
  output logic              host_irq,
  output logic              host_dmarq,
  input  logic [1:0]        dev_present,
  output logic [1:0]        dev_cs0_rd,
  output logic [1:0]        dev_cs0_wr,
  output logic [1:0]        dev_cs1_rd,
  output logic [1:0]        dev_cs1_wr,
  output logic [AW:0]       dev_reg_off,
  output logic [DW-1:0]     dev_mask,
  output logic [DW-1:0]     dev_wdata,
  input  logic [2*DW-1:0]   dev_rdata,
  output logic [1:0]        dev_dma_rd,
  output logic [1:0]        dev_dma_wr,
  output logic [DW-1:0]     dev_dma_wdata,
  input  logic [2*DW-1:0]   dev_dma_rdata,
  output logic [1:0]        dev_dmack,
  input  logic [1:0]        dev_irq,
  input  logic [1:0]        dev_dmarq,
  output logic [1:0]        dev_csel,
  output logic [1:0]        dev_dasp
);
  localparam int NP = 2;
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] FULL_LANES = {DW{1'b1}};
  localparam logic [DW-1:0] HI_LANE = {{HW{1'b1}}, {HW{1'b0}}};
  localparam logic [DW-1:0] LO_LANE = {{HW{1'b0}}, {HW{1'b1}}};

  logic          win0_act, alias_hit, hi_only;
  logic [AW-1:0] eff_off;
  logic [DW-1:0] rd_acc  [NP+1];
  logic [DW-1:0] dma_acc [NP+1];

  assign win0_act  = host_cs0_rd | host_cs0_wr;
  assign alias_hit = win0_act && (host_mask == FULL_LANES) && (host_word_off == AW'(1));
  assign hi_only   = (host_mask == HI_LANE);
  assign eff_off   = alias_hit ? '0 : host_word_off;

  assign dev_reg_off   = {eff_off, hi_only};
  assign dev_mask      = hi_only ? LO_LANE : host_mask;
  assign dev_wdata     = hi_only ? (host_wdata >> HW) : host_wdata;
  assign dev_dma_wdata = host_dma_wdata;

  assign rd_acc[0]  = dev_mask;
  assign dma_acc[0] = FULL_LANES;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign rd_acc[p+1]  = dev_present[p] ? (rd_acc[p] & dev_rdata[p*DW +: DW]) : rd_acc[p];
    assign dma_acc[p+1] = dev_present[p] ? (dma_acc[p] & dev_dma_rdata[p*DW +: DW]) : dma_acc[p];
    assign dev_cs0_rd[p] = host_cs0_rd & dev_present[p];
    assign dev_cs0_wr[p] = host_cs0_wr & dev_present[p];
    assign dev_cs1_rd[p] = host_cs1_rd & dev_present[p];
    assign dev_cs1_wr[p] = host_cs1_wr & dev_present[p];
    assign dev_dma_rd[p] = host_dma_rd & dev_present[p];
    assign dev_dma_wr[p] = host_dma_wr & dev_present[p];
    assign dev_dmack[p]  = host_dmack & dev_present[p];
    assign dev_csel[p]   = 1'(p);
    assign dev_dasp[p]   = dev_present[1];
  end

  assign host_rdata     = hi_only ? (rd_acc[NP] << HW) : rd_acc[NP];
  assign host_dma_rdata = dma_acc[NP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_irq   <= 1'b0;
      host_dmarq <= 1'b0;
    end else begin
      host_irq   <= |dev_irq;
      host_dmarq <= |dev_dmarq;
    end
  end

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_irq) |=> host_irq);
  // R9
  dmarq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_dmarq == 2'b00) |=> !host_dmarq);
  // R2
  hi_lane_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mask == HI_LANE) |-> (host_rdata[HW-1:0] == '0 && dev_reg_off[0]));
  // R4
  rdata_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mask != HI_LANE) |-> ((host_rdata & ~host_mask) == '0));
  // R6
  wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_cs0_wr || |dev_cs1_wr) |-> (host_cs0_wr || host_cs1_wr));
  // R3
  alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs0_rd && host_mask == FULL_LANES && host_word_off == AW'(1)) |-> (dev_reg_off == '0));
endmodule

// File: tb/ide_pair_adapter_tb.sv
module ide_pair_adapter_tb;
  logic clk = 0;
  logic rst_n;
  logic cs0_rd, cs0_wr, cs1_rd, cs1_wr;
  logic [2:0] woff;
  logic [15:0] mask, wdata, rdata, dma_wdata, dma_rdata;
  logic dma_rd, dma_wr, dmack, irq_o, dmarq_o;
  logic [1:0] present, d_cs0_rd, d_cs0_wr, d_cs1_rd, d_cs1_wr;
  logic [3:0] reg_off;
  logic [15:0] d_mask, d_wdata, d_dma_wdata;
  logic [31:0] d_rdata, d_dma_rdata;
  logic [1:0] d_dma_rd, d_dma_wr, d_dmack, d_irq, d_dmarq, csel, dasp;

  int tests = 0, fails = 0;
  bit done = 0;
  bit exp_irq, exp_dmarq;

  always #10 clk = ~clk;

  ide_pair_adapter u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_cs0_rd(cs0_rd), .host_cs0_wr(cs0_wr), .host_cs1_rd(cs1_rd), .host_cs1_wr(cs1_wr),
    .host_word_off(woff), .host_mask(mask), .host_wdata(wdata), .host_rdata(rdata),
    .host_dma_rd(dma_rd), .host_dma_wr(dma_wr), .host_dma_wdata(dma_wdata),
    .host_dma_rdata(dma_rdata), .host_dmack(dmack), .host_irq(irq_o), .host_dmarq(dmarq_o),
    .dev_present(present), .dev_cs0_rd(d_cs0_rd), .dev_cs0_wr(d_cs0_wr),
    .dev_cs1_rd(d_cs1_rd), .dev_cs1_wr(d_cs1_wr), .dev_reg_off(reg_off),
    .dev_mask(d_mask), .dev_wdata(d_wdata), .dev_rdata(d_rdata),
    .dev_dma_rd(d_dma_rd), .dev_dma_wr(d_dma_wr), .dev_dma_wdata(d_dma_wdata),
    .dev_dma_rdata(d_dma_rdata), .dev_dmack(d_dmack), .dev_irq(d_irq), .dev_dmarq(d_dmarq),
    .dev_csel(csel), .dev_dasp(dasp)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference, evaluated after inputs settle
  task automatic compare();
    int off;
    bit hi;
    logic [15:0] acc, dacc, emask;
    logic [1:0] g;
    off = woff;
    if ((cs0_rd || cs0_wr) && mask == 16'hFFFF && woff == 3'd1) off = 0;  // R3
    hi = (mask == 16'hFF00);
    chk(hi ? "R2 offset" : "R1_R3 offset", reg_off, off * 2 + (hi ? 1 : 0));
    emask = hi ? 16'h00FF : mask;
    chk("R1_R2 dev mask", d_mask, emask);
    chk("R1_R2 dev wdata", d_wdata, hi ? {8'h00, wdata[15:8]} : wdata);
    acc = emask;
    dacc = 16'hFFFF;
    for (int p = 0; p < 2; p++)
      if (present[p]) begin
        acc = acc & d_rdata[p*16 +: 16];
        dacc = dacc & d_dma_rdata[p*16 +: 16];
      end
    chk(hi ? "R2_R4 rdata" : "R4 rdata", rdata, hi ? {acc[7:0], 8'h00} : acc);
    chk("R5 dma rdata", dma_rdata, dacc);
    g = present;
    chk("R6 cs0 strobes", {d_cs0_rd, d_cs0_wr}, {cs0_rd ? g : 2'b00, cs0_wr ? g : 2'b00});
    chk("R6 cs1 strobes", {d_cs1_rd, d_cs1_wr}, {cs1_rd ? g : 2'b00, cs1_wr ? g : 2'b00});
    chk("R7 dma strobes", {d_dma_rd, d_dma_wr, d_dmack},
        {dma_rd ? g : 2'b00, dma_wr ? g : 2'b00, dmack ? g : 2'b00});
    chk("R7 dma wdata", d_dma_wdata, dma_wdata);
    chk("R10 straps", {csel, dasp}, {2'b10, {2{present[1]}}});
    chk(rst_n ? "R8 irq" : "R11 irq", irq_o, exp_irq);
    chk(rst_n ? "R9 dmarq" : "R11 dmarq", dmarq_o, exp_dmarq);
  endtask

  task automatic cycle();
    #2 compare();
    @(posedge clk);
    exp_irq   = rst_n && (d_irq != 0);
    exp_dmarq = rst_n && (d_dmarq != 0);
    @(negedge clk);
  endtask

  task automatic access(bit w, bit win1, logic [2:0] o, logic [15:0] m);
    {cs0_rd, cs0_wr, cs1_rd, cs1_wr} = 4'b0;
    if (!win1) begin cs0_rd = !w; cs0_wr = w; end
    else       begin cs1_rd = !w; cs1_wr = w; end
    woff = o; mask = m;
  endtask

  initial begin
    rst_n = 0;
    {cs0_rd, cs0_wr, cs1_rd, cs1_wr, dma_rd, dma_wr, dmack} = '0;
    woff = 0; mask = 16'hFFFF; wdata = 16'hA5C3; dma_wdata = 16'h1234;
    present = 2'b11; d_rdata = 32'h0F0F_FF00; d_dma_rdata = 32'h3C3C_FFFF;
    d_irq = 2'b11; d_dmarq = 2'b01;
    exp_irq = 0; exp_dmarq = 0;
    @(negedge clk);
    // R11: device lines high while in reset
    repeat (3) cycle();
    rst_n = 1;
    // R3: window 0 full mask at offset 1 is redirected; window 1 is not
    access(0, 0, 3'd1, 16'hFFFF); cycle();
    access(1, 0, 3'd1, 16'hFFFF); cycle();
    access(0, 1, 3'd1, 16'hFFFF); cycle();
    access(0, 0, 3'd1, 16'h00FF); cycle();
    // R2: upper lane
    access(1, 0, 3'd3, 16'hFF00); wdata = 16'hBE12; cycle();
    // R4: no port present, full mask reads all ones
    present = 2'b00; access(0, 0, 3'd2, 16'hFFFF); cycle();
    present = 2'b10; cycle();
    present = 2'b01; cycle();
    for (int i = 0; i < 600; i++) begin
      int mk;
      rst_n = (i % 97) != 50;
      mk = $urandom_range(0, 4);
      access($urandom_range(0, 1), $urandom_range(0, 1), 3'($urandom),
             mk == 0 ? 16'hFFFF : mk == 1 ? 16'hFF00 : mk == 2 ? 16'h00FF :
             mk == 3 ? 16'h0F0F : 16'($urandom));
      if ($urandom_range(0, 3) == 0) {cs0_rd, cs0_wr, cs1_rd, cs1_wr} = 4'b0;
      wdata = 16'($urandom); dma_wdata = 16'($urandom);
      {dma_rd, dma_wr, dmack} = 3'($urandom);
      present = 2'($urandom);
      d_rdata = $urandom; d_dma_rdata = $urandom;
      d_irq = 2'($urandom); d_dmarq = 2'($urandom);
      cycle();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule